// File: doc/BRIEF.md
# Memory Request Switch

This block is the port stage of a crossbar that lets several master request links share one memory target. Every master owns a single request channel on which address/command beats and write-data beats travel one after another on the same data field, under a valid/accept handshake. The switch passes each whole request to the memory side. A read is one beat. A write is a header beat followed by its burst of data beats. Which master may start a request is chosen by an external arbiter and arrives as a grant vector. The switch runs on the memory clock.

Reads are posted. A master may keep sending reads and writes while earlier read data is still outstanding. Memory returns read data in the order the reads were issued. To steer that data back, the switch keeps a queue of master indices, written when a read is forwarded and popped when read data arrives. The data goes out on a response path separate from the request channel. A write is complete for the master as soon as the switch accepts its last beat. The memory sends no acknowledge for writes.

Control is a two-state machine. In `SW_IDLE` the switch forwards beats from the master named by a one-hot grant. The transition *header taken* (a write header beat is transferred) moves it to `SW_BURST` and records that master as owner. In `SW_BURST` only the owner's beats are forwarded. The transition *last taken* (a beat with the last flag is transferred) returns it to `SW_IDLE`. Reset forces `SW_IDLE` and empties the queue.

Top module: `memreq_switch`

## Requirements
- R1: In `SW_IDLE`, a read beat (command bit `m_req_wr`=0) from the granted master is forwarded in the same cycle: `mem_req_valid`=1, `mem_req_wr`=0, `mem_req_last`=0, and `mem_req_data` equals that master's data slice (bits k*DW upward for master k).
- R2: A transferred write header moves the switch to `SW_BURST`. From then on only the owner's beats are forwarded, as `mem_req_wr`=1, with the grant vector ignored. `mem_req_last` copies the owner's last flag. The transfer of a last beat returns the switch to `SW_IDLE`. The last flag on a header beat is ignored and forwarded as 0.
- R3: A beat transfers only when valid and accept are both high. The selected master's accept bit equals `mem_req_accept`. All other accept bits are 0. When `mem_req_accept`=0 the beat stays on the memory side and the state is unchanged.
- R4: In `SW_IDLE`, a grant vector that is not exactly one-hot (all zero, or more than one bit set) forwards nothing: `mem_req_valid`=0 and all accept bits are 0.
- R5: Read data appears on `m_rsp_data` in the same cycle as `mem_rsp_valid`. Exactly one bit of `m_rsp_valid` is set, and it is the bit of the master that issued the oldest outstanding read.
- R6: Read responses reach masters in the global issue order of their reads, across masters.
- R7: With ORD_DEPTH reads outstanding, a granted read is refused (accept 0, `mem_req_valid`=0). Write headers and burst beats still pass.
- R8: After reset the switch is in `SW_IDLE` with no reads outstanding, even if reset struck during a burst.
- R9: A memory response that arrives while no read is outstanding raises no bit of `m_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_in | input | N_MST | Arbiter grant, one bit per master |
| m_req_valid | input | N_MST | Request beat valid per master |
| m_req_wr | input | N_MST | Beat command: 1 write, 0 read (header beats) |
| m_req_last | input | N_MST | Marks final data beat of a write burst |
| m_req_data | input | N_MST*DW | Address/command or write data, packed per master |
| m_req_accept | output | N_MST | Beat accepted, per master |
| mem_req_valid | output | 1 | Beat valid towards memory |
| mem_req_wr | output | 1 | Beat belongs to a write |
| mem_req_last | output | 1 | Final data beat of a write |
| mem_req_data | output | DW | Forwarded beat payload |
| mem_req_accept | input | 1 | Memory side takes the beat |
| mem_rsp_valid | input | 1 | Read data valid from memory |
| mem_rsp_data | input | DW | Read data from memory |
| m_rsp_valid | output | N_MST | Read data valid, per master |
| m_rsp_data | output | DW | Read data broadcast to masters |

## Verification
The request path is driven with single-master reads, a full write burst, and cycles where several masters are valid at once. The several-master cycles show that only the granted slice reaches memory. Burst beats are sent while the grant has moved elsewhere, which separates a correct ownership lock from plain grant following. Memory backpressure in the middle of a burst tells a stalled beat from a skipped one. Grants of zero and of two bits confirm that nothing leaks through without an exact grant. The response path is exercised with interleaved reads from different masters until the queue is full. A further read is then refused while a write still passes. The queue is drained in order, and a surplus response confirms that it is dropped.

// File: rtl/memreq_pkg.sv
package memreq_pkg;

    typedef enum logic [0:0] {
        SW_IDLE  = 1'b0,
        SW_BURST = 1'b1
    } sw_state_e;

endpackage

// File: rtl/memreq_order_fifo.sv
module memreq_order_fifo #(
    parameter int N_MST = 3,
    parameter int DEPTH = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 push,
    input  logic [((N_MST > 1) ? $clog2(N_MST) : 1)-1:0] push_id,
    input  logic                                 pop,
    output logic [((N_MST > 1) ? $clog2(N_MST) : 1)-1:0] head_id,
    output logic                                 empty,
    output logic                                 full
);
    localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1;
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDW-1:0] slots [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [PW:0]    fill;

    assign empty   = (fill == '0);
    assign full    = (fill == (PW+1)'(DEPTH));
    assign head_id = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_id;
                wr_ptr        <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/memreq_beat_sel.sv
module memreq_beat_sel #(
    parameter int N_MST = 3,
    parameter int DW    = 32
) (
    input  logic [N_MST-1:0]    sel,
    input  logic [N_MST-1:0]    valid,
    input  logic [N_MST-1:0]    wr,
    input  logic [N_MST-1:0]    last,
    input  logic [N_MST*DW-1:0] data,
    output logic                b_valid,
    output logic                b_wr,
    output logic                b_last,
    output logic [DW-1:0]       b_data,
    output logic [((N_MST > 1) ? $clog2(N_MST) : 1)-1:0] b_idx
);
    localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1;

    logic [DW-1:0] slot_data [N_MST];

    for (genvar k = 0; k < N_MST; k++) begin : g_slot
        assign slot_data[k] = data[k*DW +: DW] & {DW{sel[k]}};
    end

    assign b_valid = |(sel & valid);
    assign b_wr    = |(sel & wr);
    assign b_last  = |(sel & last);

    always_comb begin
        b_data = '0;
        b_idx  = '0;
        for (int k = 0; k < N_MST; k++) begin
            b_data = b_data | slot_data[k];
            if (sel[k]) b_idx = IDW'(k);
        end
    end
endmodule

// File: rtl/memreq_switch.sv
module memreq_switch
    import memreq_pkg::*;
#(
    parameter int N_MST     = 3,
    parameter int DW        = 32,
    parameter int ORD_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MST-1:0]    grant_in,
    input  logic [N_MST-1:0]    m_req_valid,
    input  logic [N_MST-1:0]    m_req_wr,
    input  logic [N_MST-1:0]    m_req_last,
    input  logic [N_MST*DW-1:0] m_req_data,
    output logic [N_MST-1:0]    m_req_accept,
    output logic                mem_req_valid,
    output logic                mem_req_wr,
    output logic                mem_req_last,
    output logic [DW-1:0]       mem_req_data,
    input  logic                mem_req_accept,
    input  logic                mem_rsp_valid,
    input  logic [DW-1:0]       mem_rsp_data,
    output logic [N_MST-1:0]    m_rsp_valid,
    output logic [DW-1:0]       m_rsp_data
);
    localparam int IDW = (N_MST > 1) ? $clog2(N_MST) : 1;

    sw_state_e        state_q, state_d;
    logic [N_MST-1:0] owner_q, owner_d;
    logic [N_MST-1:0] sel;
    logic             grant_ok;

    logic             b_valid, b_wr, b_last;
    logic [DW-1:0]    b_data;
    logic [IDW-1:0]   b_idx;

    logic             is_read, blocked, xfer;
    logic             q_push, q_pop, q_empty, q_full;
    logic [IDW-1:0]   q_head;

    assign grant_ok = (grant_in != '0) && ((grant_in & (grant_in - 1'b1)) == '0);

    memreq_beat_sel #(.N_MST(N_MST), .DW(DW)) u_sel (
        .sel    (sel),
        .valid  (m_req_valid),
        .wr     (m_req_wr),
        .last   (m_req_last),
        .data   (m_req_data),
        .b_valid(b_valid),
        .b_wr   (b_wr),
        .b_last (b_last),
        .b_data (b_data),
        .b_idx  (b_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // Selection and next state
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        sel     = '0;
        unique case (state_q)
            SW_IDLE: begin
                sel = grant_ok ? grant_in : '0;
                if (xfer && b_wr) begin
                    state_d = SW_BURST;
                    owner_d = sel;
                end
            end
            SW_BURST: begin
                sel = owner_q;
                if (xfer && b_last) begin
                    state_d = SW_IDLE;
                    owner_d = '0;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        is_read       = (state_q == SW_IDLE) && !b_wr;
        blocked       = is_read && q_full;
        mem_req_valid = b_valid && !blocked;
        mem_req_wr    = (state_q == SW_BURST) || b_wr;
        mem_req_last  = (state_q == SW_BURST) && b_last;
        mem_req_data  = b_data;
        m_req_accept  = (mem_req_accept && !blocked) ? sel : '0;
        xfer          = mem_req_valid && mem_req_accept;
        q_push        = xfer && is_read;
        q_pop         = mem_rsp_valid && !q_empty;
        m_rsp_valid   = q_pop ? ({{(N_MST-1){1'b0}}, 1'b1} << q_head) : '0;
        m_rsp_data    = mem_rsp_data;
    end

    memreq_order_fifo #(.N_MST(N_MST), .DEPTH(ORD_DEPTH)) u_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (q_push),
        .push_id(b_idx),
        .pop    (q_pop),
        .head_id(q_head),
        .empty  (q_empty),
        .full   (q_full)
    );
endmodule

// File: rtl/memreq_checker.sv
module memreq_checker #(
    parameter int N_MST     = 3,
    parameter int ORD_DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] m_req_accept,
    input logic             mem_req_valid,
    input logic             mem_req_wr,
    input logic             mem_req_last,
    input logic             mem_req_accept,
    input logic             mem_rsp_valid,
    input logic [N_MST-1:0] m_rsp_valid
);
    localparam int CW = $clog2(ORD_DEPTH) + 1;

    logic [CW-1:0] outstanding;
    logic          rd_xfer, rsp_pop;

    assign rd_xfer = mem_req_valid && mem_req_accept && !mem_req_wr;
    assign rsp_pop = mem_rsp_valid && (outstanding != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else        outstanding <= outstanding + CW'(rd_xfer) - CW'(rsp_pop);
    end

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_req_accept)); // R3
    AST_ACCEPT_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req_accept != '0) |-> mem_req_accept); // R3
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_accept && mem_req_wr && !mem_req_last)
        |=> (m_req_accept == '0 || m_req_accept == $past(m_req_accept))); // R2
    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_rsp_valid)); // R5
    AST_RSP_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rsp_valid != '0) |-> mem_rsp_valid); // R5
    AST_QUEUE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == CW'(ORD_DEPTH)) |-> !(mem_req_valid && !mem_req_wr)); // R7
    AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding == '0) |-> (m_rsp_valid == '0)); // R9
endmodule

bind memreq_switch memreq_checker #(.N_MST(N_MST), .ORD_DEPTH(ORD_DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_req_accept  (m_req_accept),
    .mem_req_valid (mem_req_valid),
    .mem_req_wr    (mem_req_wr),
    .mem_req_last  (mem_req_last),
    .mem_req_accept(mem_req_accept),
    .mem_rsp_valid (mem_rsp_valid),
    .m_rsp_valid   (m_rsp_valid)
);

// File: tb/sim_memreq_switch.sv
module sim_memreq_switch;
    localparam int N  = 3;
    localparam int DW = 32;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  grant_in = '0, m_req_valid = '0, m_req_wr = '0, m_req_last = '0;
    logic [N*DW-1:0] m_req_data = '0;
    logic [N-1:0]  m_req_accept, m_rsp_valid;
    logic          mem_req_valid, mem_req_wr, mem_req_last;
    logic [DW-1:0] mem_req_data, m_rsp_data;
    logic          mem_req_accept = 1'b0, mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    memreq_switch #(.N_MST(N), .DW(DW), .ORD_DEPTH(QD)) u0 (.*);

    typedef struct packed {
        logic [2:0] gnt, vld, wr, last;
        logic       macc;
        logic [2:0] acc;
        logic       mv, mwr, mlast;
        logic [1:0] src;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{3'b001, 3'b111, 3'b000, 3'b000, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 2'd0}, // R1 read m0, others valid
        '{3'b010, 3'b010, 3'b010, 3'b010, 1'b1, 3'b010, 1'b1, 1'b1, 1'b0, 2'd1}, // R2 header m1, last ignored
        '{3'b100, 3'b110, 3'b000, 3'b000, 1'b1, 3'b010, 1'b1, 1'b1, 1'b0, 2'd1}, // R2 grant moved, owner kept
        '{3'b100, 3'b110, 3'b000, 3'b010, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 2'd1}, // R3 backpressure
        '{3'b100, 3'b110, 3'b000, 3'b010, 1'b1, 3'b010, 1'b1, 1'b1, 1'b1, 2'd1}, // R2 last beat taken
        '{3'b100, 3'b100, 3'b000, 3'b000, 1'b1, 3'b100, 1'b1, 1'b0, 1'b0, 2'd2}, // R1 read m2 after burst
        '{3'b011, 3'b011, 3'b000, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 two-bit grant
        '{3'b000, 3'b111, 3'b000, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 2'd0}, // R4 zero grant
        '{3'b001, 3'b000, 3'b000, 3'b000, 1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 2'd0}, // R3 accept, no valid
        '{3'b001, 3'b001, 3'b000, 3'b000, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 2'd0}  // R6 read m0 again
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] g, input logic [2:0] v, input logic [2:0] w,
                         input logic [2:0] l, input logic ma, input int tag);
        @(negedge clk);
        grant_in = g; m_req_valid = v; m_req_wr = w; m_req_last = l; mem_req_accept = ma;
        for (int k = 0; k < N; k++) m_req_data[k*DW +: DW] = {8'(k+1), 24'(tag)};
        #1;
    endtask

    task automatic rsp(input logic [DW-1:0] d, input logic [2:0] exp_v, input string req);
        @(negedge clk);
        m_req_valid = '0; mem_rsp_valid = 1'b1; mem_rsp_data = d;
        #1;
        chk(req, 64'(m_rsp_valid), 64'(exp_v));
        if (exp_v != '0) chk(req, 64'(m_rsp_data), 64'(d));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R8 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R8 reset accept", 64'(m_req_accept), 64'd0);
        rst_n = 1'b1;
        rsp(32'hDEAD0000, 3'b000, "R8 R9 empty queue after reset");

        for (int i = 0; i < 10; i++) begin
            mem_rsp_valid = 1'b0;
            drive(VECS[i].gnt, VECS[i].vld, VECS[i].wr, VECS[i].last, VECS[i].macc, i);
            chk($sformatf("R1-vec%0d accept", i), 64'(m_req_accept), 64'(VECS[i].acc));
            chk($sformatf("R3-vec%0d valid", i), 64'(mem_req_valid), 64'(VECS[i].mv));
            if (VECS[i].mv) begin
                chk($sformatf("R2-vec%0d wr", i), 64'(mem_req_wr), 64'(VECS[i].mwr));
                chk($sformatf("R2-vec%0d last", i), 64'(mem_req_last), 64'(VECS[i].mlast));
                chk($sformatf("R1-vec%0d data", i), 64'(mem_req_data),
                    64'({8'(VECS[i].src + 1), 24'(i)}));
            end
        end

        // R7: fourth read fills the queue, fifth is refused
        drive(3'b010, 3'b010, 3'b000, 3'b000, 1'b1, 20);
        chk("R7 fill read accepted", 64'(m_req_accept), 64'(3'b010));
        drive(3'b100, 3'b100, 3'b000, 3'b000, 1'b1, 21);
        chk("R7 full read refused accept", 64'(m_req_accept), 64'd0);
        chk("R7 full read refused valid", 64'(mem_req_valid), 64'd0);
        drive(3'b100, 3'b100, 3'b100, 3'b000, 1'b1, 22);
        chk("R7 write header while full", 64'(m_req_accept), 64'(3'b100));
        chk("R7 write header valid", 64'(mem_req_valid), 64'd1);
        drive(3'b001, 3'b100, 3'b000, 3'b100, 1'b1, 23);
        chk("R7 burst beat while full", 64'(m_req_accept), 64'(3'b100));
        chk("R2 burst last", 64'(mem_req_last), 64'd1);

        // R5 R6: responses in issue order m0, m2, m0, m1
        rsp(32'h1111_0001, 3'b001, "R6 first response m0");
        rsp(32'h1111_0002, 3'b100, "R5 second response m2");
        rsp(32'h1111_0003, 3'b001, "R6 third response m0");
        rsp(32'h1111_0004, 3'b010, "R6 fourth response m1");
        rsp(32'h1111_0005, 3'b000, "R9 surplus response dropped");
        mem_rsp_valid = 1'b0;

        // R8: reset in the middle of a burst
        drive(3'b001, 3'b001, 3'b001, 3'b000, 1'b1, 30);
        chk("R8 header before reset", 64'(m_req_accept), 64'(3'b001));
        @(negedge clk);
        rst_n = 1'b0; m_req_valid = '0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'b010, 3'b011, 3'b000, 3'b000, 1'b1, 31);
        chk("R8 idle after reset accept", 64'(m_req_accept), 64'(3'b010));
        chk("R8 idle after reset wr", 64'(mem_req_wr), 64'd0);
        chk("R8 idle after reset data", 64'(mem_req_data), 64'({8'd2, 24'd31}));
        drive(3'b000, 3'b000, 3'b000, 3'b000, 1'b1, 32);
        rsp(32'h2222_0001, 3'b010, "R8 queue cleared then R5 one entry");
        rsp(32'h2222_0002, 3'b000, "R9 drop after drain");
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule